// File: doc/BRIEF.md
# SPD Base-Region CRC Checker

This block checks the integrity of the fixed base region at the start of a DDR5 serial presence detect image. Whatever fetches the image presents it one byte per cycle with `valid_i`, starting at byte 0. The block runs a 16-bit CRC over the leading 510 bytes. It picks up the reference checksum carried in the final two bytes of the 512-byte region. When the last byte arrives it raises a completion flag and a compare result, and it shows both the computed and the carried values.

A one-cycle `start_i` pulse arms the checker for a new region. The byte position is implicit: the block counts accepted bytes, so no address is supplied. Extra bytes past the region end are discarded. The results stay visible until the next arm pulse.

Top module: `spd_crc_chk`

## Requirements
- R1: After reset, `done_o` and `match_o` are 0, `crc_calc_o` and `crc_stored_o` are 0x0000, and the next accepted byte is treated as byte 0.
- R2: A `start_i` pulse clears the byte position, the running CRC (to 0x0000), the captured reference and `done_o`. A byte presented with `valid_i` in the same cycle as `start_i` is discarded.
- R3: The CRC uses polynomial 0x1021 with initial value 0x0000, most significant bit first, no bit reflection and no final XOR. After the ASCII bytes "123456789" as bytes 0..8, `crc_calc_o` reads 0x31C3. `crc_calc_o` shows each byte's contribution from the cycle after that byte is accepted.
- R4: Only bytes 0 through 509 enter the CRC. The contents of bytes 510 and 511 have no effect on `crc_calc_o`.
- R5: `crc_stored_o` is byte 511 in bits 15:8 and byte 510 in bits 7:0. For example, 0x37 then 0x3E gives 0x3E37.
- R6: A byte is accepted only in a cycle where `valid_i` is 1. Idle cycles do not advance the position. `done_o` rises in the cycle after byte 511 is accepted and not before.
- R7: While `done_o` is 1, `match_o` is 1 exactly when `crc_calc_o` equals `crc_stored_o`. A mismatch gives `done_o`=1 with `match_o`=0. `match_o` is 0 while `done_o` is 0.
- R8: Valid bytes after byte 511 are ignored. `done_o`, `match_o`, `crc_calc_o` and `crc_stored_o` keep their values until the next `start_i`.
- R9: A `start_i` in the middle of a region discards the partial result, and the following bytes are counted from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle arm pulse for a new region |
| valid_i | input | 1 | `data_i` carries the next image byte |
| data_i | input | 8 | Image byte |
| done_o | output | 1 | Region complete |
| match_o | output | 1 | Computed CRC equals carried CRC (qualified by `done_o`) |
| crc_calc_o | output | 16 | CRC over bytes 0..509 |
| crc_stored_o | output | 16 | Reference CRC from bytes 510/511 |

## Verification
The hardest situation to reach from the ports is proving that the two trailing bytes stay out of the CRC while also being captured in the right order. A single good image cannot show this, because a matching image hides a swapped or included byte only by coincidence. The stimulus therefore sends the same 510-byte body several times, each with a different tail: the correct CRC, a corrupted CRC, and the pair 0x37/0x3E. It then checks that `crc_calc_o` never changes while `crc_stored_o` follows the tail. Idle gaps, an arm pulse in the middle of a region and overrun bytes are mixed in so that the byte position is exercised apart from the cycle count.

// File: rtl/spd_crc_pkg.sv
// Package: shared constants and types for the SPD base-region CRC checker.
// Assumes byte-wide input and a CRC width that is a whole number of bytes.
package spd_crc_pkg;
    localparam int          SPD_REGION_BYTES = 512;
    localparam int          SPD_CRC_W        = 16;
    localparam logic [15:0] SPD_CRC_POLY     = 16'h1021;
    localparam logic [15:0] SPD_CRC_INIT     = 16'h0000;

    typedef logic [7:0] spd_byte_t;
endpackage

// File: rtl/spd_byte_ctr.sv
// Module: spd_byte_ctr
// Counts accepted bytes of the region and produces the accept strobe.
// Assumes start_i has priority over valid_i; the count saturates at
// REGION_BYTES, so bytes past the region are never accepted.
module spd_byte_ctr #(
    parameter int REGION_BYTES = 512,
    localparam int CW          = $clog2(REGION_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          valid_i,
    output logic          accept_o,
    output logic [CW-1:0] idx_o
);
    logic [CW-1:0] cnt_q;

    // Accept a byte only while armed and the region is not yet complete.
    always_comb accept_o = valid_i && !start_i && (cnt_q < CW'(REGION_BYTES));

    // Position register: cleared by reset or start, advanced per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) cnt_q <= '0;
        else if (accept_o)     cnt_q <= cnt_q + 1'b1;
    end

    assign idx_o = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(REGION_BYTES));                                  // R8
endmodule

// File: rtl/spd_crc16_eng.sv
// Module: spd_crc16_eng
// Byte-serial CRC register, MSB first, non-reflected, no final XOR.
// Assumes en_i and clear_i are never needed in the same cycle (clear wins).
module spd_crc16_eng #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   POLY = 16'h1021,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         en_i,
    input  logic [7:0]   data_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_q;

    // Fold one byte into the CRC, feeding data bits from bit 7 down.
    function automatic logic [W-1:0] fold_byte(input logic [W-1:0] c, input logic [7:0] d);
        logic [W-1:0] r;
        logic         fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[W-1] ^ d[i];
            r  = {r[W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    // CRC state: initial value on reset/clear, fold on enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) crc_q <= INIT;
        else if (en_i)         crc_q <= fold_byte(crc_q, data_i);
    end

    assign crc_o = crc_q;

    AST_CRC_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !en_i) |=> $stable(crc_o));                     // R4
endmodule

// File: rtl/spd_ref_capture.sv
// Module: spd_ref_capture
// Captures the trailing reference bytes, lowest address into lowest byte lane.
// Assumes idx_i is the position of the byte being accepted this cycle.
module spd_ref_capture #(
    parameter int  W       = 16,
    parameter int  FIRST   = 510,
    parameter int  CW      = 10,
    localparam int NB      = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          accept_i,
    input  logic [CW-1:0] idx_i,
    input  logic [7:0]    data_i,
    output logic [W-1:0]  ref_o
);
    for (genvar k = 0; k < NB; k++) begin : g_lane
        logic [7:0] lane_q;
        // Lane k takes the byte at position FIRST+k.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)                          lane_q <= '0;
            else if (accept_i && idx_i == CW'(FIRST + k))   lane_q <= data_i;
        end
        assign ref_o[8*k +: 8] = lane_q;
    end
endmodule

// File: rtl/spd_crc_chk.sv
// Module: spd_crc_chk (top)
// Streams a 512-byte SPD base region, CRCs bytes 0..509, captures the
// reference from bytes 510/511 (low byte first) and reports completion
// and match. Assumes bytes arrive in address order from byte 0 after start.
module spd_crc_chk
    import spd_crc_pkg::*;
#(
    parameter int           REGION_BYTES = SPD_REGION_BYTES,
    parameter int           CRC_W        = SPD_CRC_W,
    parameter logic [15:0]  CRC_POLY     = SPD_CRC_POLY,
    parameter logic [15:0]  CRC_INIT     = SPD_CRC_INIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic [7:0]       data_i,
    output logic             done_o,
    output logic             match_o,
    output logic [CRC_W-1:0] crc_calc_o,
    output logic [CRC_W-1:0] crc_stored_o
);
    localparam int CW    = $clog2(REGION_BYTES + 1);
    localparam int SPAN  = REGION_BYTES - CRC_W / 8;
    localparam int LAST  = REGION_BYTES - 1;

    logic          accept;
    logic [CW-1:0] idx;
    logic          done_q;

    spd_byte_ctr #(.REGION_BYTES(REGION_BYTES)) u_ctr (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .accept_o(accept), .idx_o(idx)
    );

    spd_crc16_eng #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i),
        .en_i(accept && idx < CW'(SPAN)), .data_i(data_i), .crc_o(crc_calc_o)
    );

    spd_ref_capture #(.W(CRC_W), .FIRST(SPAN), .CW(CW)) u_ref (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .accept_i(accept),
        .idx_i(idx), .data_i(data_i), .ref_o(crc_stored_o)
    );

    // Completion flag: set when the final region byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)                  done_q <= 1'b0;
        else if (accept && idx == CW'(LAST))    done_q <= 1'b1;
    end

    // Compare result, qualified by completion.
    always_comb match_o = done_q && (crc_calc_o == crc_stored_o);

    assign done_o = done_q;

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);                             // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(crc_calc_o) && $stable(crc_stored_o))); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && crc_calc_o == CRC_INIT && crc_stored_o == '0)); // R2
    AST_DONE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(valid_i));                            // R6
    AST_MATCH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !match_o);                                        // R7
endmodule

// File: tb/spd_crc_chk_tb.sv
// Directed bench for spd_crc_chk: one task per scenario, each self-checking.
module spd_crc_chk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        done_o, match_o;
    logic [15:0] crc_calc_o, crc_stored_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    spd_crc_chk u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .done_o(done_o), .match_o(match_o),
        .crc_calc_o(crc_calc_o), .crc_stored_o(crc_stored_o)
    );

    // Reference CRC step written from the requirement (poly 0x1021, MSB first).
    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] img(input int i);
        return 8'(i * 13 + (i >> 4) + 5);
    endfunction

    function automatic logic [15:0] body_crc();
        logic [15:0] c;
        c = 16'h0000;
        for (int i = 0; i < 510; i++) c = ref_step(c, img(i));
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Caller is at a negedge; present one byte for one cycle.
    task automatic put(input logic [7:0] b);
        valid_i = 1'b1; data_i = b;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Body bytes 0..509 then the two given tail bytes, with gap idle cycles.
    task automatic feed(input int gap, input logic [7:0] t0, input logic [7:0] t1);
        for (int i = 0; i < 510; i++) begin put(img(i)); idle(gap); end
        put(t0); idle(gap);
        check("R6 done low before byte 511", {31'b0, done_o}, 32'd0);
        put(t1);
    endtask

    task automatic t_reset();
        check("R1 done after reset", {31'b0, done_o}, 32'd0);
        check("R1 match after reset", {31'b0, match_o}, 32'd0);
        check("R1 calc after reset", {16'b0, crc_calc_o}, 32'h0);
        check("R1 stored after reset", {16'b0, crc_stored_o}, 32'h0);
        put(8'h31);
        check("R1 first byte enters CRC", {16'b0, crc_calc_o}, {16'b0, ref_step(16'h0, 8'h31)});
    endtask

    task automatic t_check_value();
        string s;
        s = "123456789";
        arm();
        for (int i = 0; i < 9; i++) put(s[i]);
        check("R3 check value", {16'b0, crc_calc_o}, 32'h31C3);
        check("R6 no done mid-region", {31'b0, done_o}, 32'd0);
    endtask

    task automatic t_good(input int gap);
        logic [15:0] c;
        c = body_crc();
        arm();
        feed(gap, c[7:0], c[15:8]);
        check("R6 done after byte 511", {31'b0, done_o}, 32'd1);
        check("R7 match on good image", {31'b0, match_o}, 32'd1);
        check("R3 calc over body", {16'b0, crc_calc_o}, {16'b0, c});
        check("R5 stored good", {16'b0, crc_stored_o}, {16'b0, c});
    endtask

    task automatic t_bad();
        logic [15:0] c;
        c = body_crc();
        arm();
        feed(0, c[7:0] ^ 8'h01, c[15:8]);
        check("R7 done on bad image", {31'b0, done_o}, 32'd1);
        check("R7 mismatch flagged", {31'b0, match_o}, 32'd0);
        check("R4 calc independent of tail", {16'b0, crc_calc_o}, {16'b0, c});
    endtask

    task automatic t_order();
        arm();
        feed(0, 8'h37, 8'h3E);
        check("R5 byte order", {16'b0, crc_stored_o}, 32'h3E37);
        check("R4 calc unaffected by tail", {16'b0, crc_calc_o}, {16'b0, body_crc()});
        check("R7 mismatch", {31'b0, match_o}, 32'd0);
    endtask

    task automatic t_overrun();
        logic [15:0] c;
        c = body_crc();
        arm();
        feed(0, c[7:0], c[15:8]);
        for (int i = 0; i < 6; i++) put(8'hA5 + 8'(i));
        check("R8 done held", {31'b0, done_o}, 32'd1);
        check("R8 match held", {31'b0, match_o}, 32'd1);
        check("R8 calc held", {16'b0, crc_calc_o}, {16'b0, c});
        check("R8 stored held", {16'b0, crc_stored_o}, {16'b0, c});
    endtask

    task automatic t_restart();
        logic [15:0] c;
        c = body_crc();
        arm();
        for (int i = 0; i < 100; i++) put(8'hFF);
        arm();
        check("R2 calc cleared", {16'b0, crc_calc_o}, 32'h0);
        check("R2 done cleared", {31'b0, done_o}, 32'd0);
        feed(0, c[7:0], c[15:8]);
        check("R9 restart gives match", {31'b0, match_o}, 32'd1);
    endtask

    task automatic t_start_with_valid();
        string s;
        s = "123456789";
        start_i = 1'b1; valid_i = 1'b1; data_i = 8'h55;
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0;
        check("R2 byte with start dropped", {16'b0, crc_calc_o}, 32'h0);
        for (int i = 0; i < 9; i++) put(s[i]);
        check("R2 sequence after start+valid", {16'b0, crc_calc_o}, 32'h31C3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_check_value();
        t_good(0);
        t_good(1);
        t_bad();
        t_order();
        t_overrun();
        t_restart();
        t_start_with_valid();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule